// File: doc/BRIEF.md
# Register Configuration Table Engine

This block walks a list of register-update records stored in memory and applies each one to its target address as a read-modify-write. Each record has three 32-bit words, fetched in this order: the target address, then a mask of bits to force high, then a mask of bits to force low. The engine works through the list until it reaches a record made of three zero words, and then it stops. It is used to apply a batch of register settings to a device without a processor running each access.

A pulse on the start input captures the table base address and begins the walk. From then on, one bus master port carries all traffic. That traffic is the table fetches, the reads of each target, and the writes back to each target. The port has at most one request outstanding, and each request stays asserted until the response arrives. Busy stays high for the whole walk. Done pulses once at the end, and an error flag reports whether a bus error cut the walk short.

Top module: `reg_cfg_walker`

## Requirements
- R1: While reset is asserted and right after it is released, busy_o, done_o, err_o, req_o and we_o are all low.
- R2: When start_i is high in the idle state, the engine latches base_addr_i. In the next cycle, busy_o is high and a read request (req_o=1, we_o=0) is issued at addr_o equal to that base.
- R3: The three words of a record are read at consecutive byte addresses p, p+4 and p+8. The word at p is the target address, the word at p+4 is the set mask and the word at p+8 is the clear mask.
- R4: For each record that is not a terminator, the engine reads the target address once and then writes the same target address once. No other access comes between that read and that write.
- R5: The value written is (old AND NOT clear) OR set, so a bit that is high in both masks ends up set.
- R6: After a record's write completes, the next record is fetched at p+12.
- R7: A record whose three words are all zero ends the walk without any access to a target. In the cycle after the final response, busy_o and req_o are low and done_o is high, and done_o is high for exactly one cycle.
- R8: Target address zero is legal. A record with address zero and a non-zero mask is applied like any other record.
- R9: A response with the error flag set ends the walk at once, with no further accesses. err_o goes high together with the one-cycle done_o pulse. err_o stays high until the next accepted start, which clears it.
- R10: A start_i pulse while busy_o is high has no effect on the walk in progress.
- R11: While a request waits for its response, req_o, addr_o, we_o and wdata_o stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, used only when the engine is idle |
| base_addr_i | input | AW | Byte address of the first record |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse when a walk ends |
| err_o | output | 1 | The last walk was ended by a bus error |
| req_o | output | 1 | Bus request valid |
| we_o | output | 1 | Bus request is a write |
| addr_o | output | AW | Bus byte address |
| wdata_o | output | DW | Bus write data |
| rsp_valid_i | input | 1 | Response for the pending request |
| rsp_err_i | input | 1 | Response carries an error |
| rsp_rdata_i | input | DW | Response read data |

## Verification
The first table has three kinds of record. One record has disjoint masks, which shows whether the clear mask and the set mask act on the correct bits. One record has overlapping masks, which separates "set wins" from "clear wins". One record targets address zero, which shows whether a zero address is wrongly taken as the end of the table. A table that holds only a terminator shows that a walk can end without touching any target. A table whose first target read returns an error shows that the walk aborts and that the error flag is sticky. A clean rerun of the same table then shows that the flag clears on the next start. The slave response latency varies from zero to two cycles. Because of this, request holding and pointer advance are checked under both immediate and delayed responses.

// File: rtl/cfg_walk_pkg.sv
package cfg_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_F_ADDR,
    ST_F_SET,
    ST_F_CLR,
    ST_T_RD,
    ST_T_WR
  } walk_st_e;
endpackage

// File: rtl/cfg_walk_rec.sv
module cfg_walk_rec #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rdata_i,
  input  logic          cap_addr_i,
  input  logic          cap_set_i,
  input  logic          cap_clr_i,
  input  logic          cap_old_i,
  output logic [AW-1:0] tgt_addr_o,
  output logic          term_o,
  output logic [DW-1:0] wdata_o
);
  logic [DW-1:0] addr_q, set_q, clr_q, old_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      set_q  <= '0;
      clr_q  <= '0;
      old_q  <= '0;
    end else begin
      if (cap_addr_i) addr_q <= rdata_i;
      if (cap_set_i)  set_q  <= rdata_i;
      if (cap_clr_i)  clr_q  <= rdata_i;
      if (cap_old_i)  old_q  <= rdata_i;
    end
  end

  assign tgt_addr_o = addr_q[AW-1:0];
  // terminator decided on the clear word as it arrives
  assign term_o  = (addr_q == '0) && (set_q == '0) && (rdata_i == '0);
  // set mask applied last so it overrides clear
  assign wdata_o = (old_q & ~clr_q) | set_q;
endmodule

// File: rtl/cfg_walk_ctrl.sv
module cfg_walk_ctrl
  import cfg_walk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          rsp_valid_i,
  input  logic          rsp_err_i,
  input  logic          term_i,
  input  logic [AW-1:0] tgt_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic          cap_addr_o,
  output logic          cap_set_o,
  output logic          cap_clr_o,
  output logic          cap_old_o
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  walk_st_e    st_q, st_d;
  logic [AW-1:0] ptr_q;
  logic        done_q, err_q;
  logic        hs, ok, abort, fin, go, fetch;

  assign hs    = req_o & rsp_valid_i;
  assign ok    = hs & ~rsp_err_i;
  assign abort = hs & rsp_err_i;
  assign go    = (st_q == ST_IDLE) & start_i;
  assign fetch = (st_q == ST_F_ADDR) | (st_q == ST_F_SET) | (st_q == ST_F_CLR);

  always_comb begin
    st_d       = st_q;
    fin        = 1'b0;
    cap_addr_o = 1'b0;
    cap_set_o  = 1'b0;
    cap_clr_o  = 1'b0;
    cap_old_o  = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_F_ADDR;
      ST_F_ADDR: if (ok) begin cap_addr_o = 1'b1; st_d = ST_F_SET; end
      ST_F_SET:  if (ok) begin cap_set_o = 1'b1; st_d = ST_F_CLR; end
      ST_F_CLR:  if (ok) begin
                   cap_clr_o = 1'b1;
                   fin       = term_i;
                   st_d      = term_i ? ST_IDLE : ST_T_RD;
                 end
      ST_T_RD:   if (ok) begin cap_old_o = 1'b1; st_d = ST_T_WR; end
      ST_T_WR:   if (ok) st_d = ST_F_ADDR;
      default:   st_d = ST_IDLE;
    endcase
    if (abort) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin | abort;
      if (go)              ptr_q <= base_addr_i;
      else if (ok & fetch) ptr_q <= ptr_q + STEP;
      if (go)         err_q <= 1'b0;
      else if (abort) err_q <= 1'b1;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign req_o  = busy_o;
  assign we_o   = (st_q == ST_T_WR);
  assign addr_o = ((st_q == ST_T_RD) || (st_q == ST_T_WR)) ? tgt_addr_i : ptr_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rsp_valid_i) |=> (req_o && $stable(addr_o) && $stable(we_o)));
  assert_err_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && rsp_valid_i && rsp_err_i) |=> (done_o && err_o && !busy_o));
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !req_o));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_write_follows_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_o) |-> ($past(req_o) && !$past(we_o) && $past(addr_o) == addr_o));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !rsp_valid_i) |=> (busy_o && $stable(addr_o)));
endmodule

// File: rtl/reg_cfg_walker.sv
module reg_cfg_walker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_err_i,
  input  logic [DW-1:0] rsp_rdata_i
);
  logic          cap_addr, cap_set, cap_clr, cap_old, term;
  logic [AW-1:0] tgt_addr;

  cfg_walk_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .base_addr_i (base_addr_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_err_i   (rsp_err_i),
    .term_i      (term),
    .tgt_addr_i  (tgt_addr),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .req_o       (req_o),
    .we_o        (we_o),
    .addr_o      (addr_o),
    .cap_addr_o  (cap_addr),
    .cap_set_o   (cap_set),
    .cap_clr_o   (cap_clr),
    .cap_old_o   (cap_old)
  );

  cfg_walk_rec #(.AW(AW), .DW(DW)) u_rec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rdata_i    (rsp_rdata_i),
    .cap_addr_i (cap_addr),
    .cap_set_i  (cap_set),
    .cap_clr_i  (cap_clr),
    .cap_old_i  (cap_old),
    .tgt_addr_o (tgt_addr),
    .term_o     (term),
    .wdata_o    (wdata_o)
  );

  assert_wdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o && !rsp_valid_i) |=> $stable(wdata_o));
endmodule

// File: tb/reg_cfg_walker_tb.sv
module reg_cfg_walker_tb;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          busy_o, done_o, err_o, req_o, we_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] wdata_o;
  logic          rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [DW-1:0] rsp_rdata = '0;

  reg_cfg_walker #(.AW(AW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base_addr),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .req_o(req_o), .we_o(we_o),
    .addr_o(addr_o), .wdata_o(wdata_o), .rsp_valid_i(rsp_valid),
    .rsp_err_i(rsp_err), .rsp_rdata_i(rsp_rdata)
  );

  logic [31:0] mem [logic [31:0]];
  logic [31:0] sh  [logic [31:0]];
  logic [31:0] e_addr[$];
  logic        e_we[$];
  logic [31:0] e_data[$];
  int checks = 0, errors = 0, txn_cnt = 0, exp_n = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] srd(input logic [31:0] a);
    return sh.exists(a) ? sh[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic w, input logic [31:0] d);
    e_addr.push_back(a); e_we.push_back(w); e_data.push_back(d);
  endtask

  // behavioural model of the expected access stream
  task automatic build(input logic [31:0] base);
    logic [31:0] p, a, s, c, nv;
    p = base;
    sh = mem;
    e_addr.delete(); e_we.delete(); e_data.delete();
    for (int i = 0; i < 16; i++) begin
      a = srd(p); s = srd(p + 4); c = srd(p + 8);
      push(p, 1'b0, 0); push(p + 4, 1'b0, 0); push(p + 8, 1'b0, 0);
      if (a == 0 && s == 0 && c == 0) break;
      push(a, 1'b0, 0);
      if (err_en && a == err_addr) break;
      nv = (srd(a) & ~c) | s;
      push(a, 1'b1, nv);
      sh[a] = nv;
      p = p + 12;
    end
    exp_n = e_addr.size();
  endtask

  // slave with 0..2 cycle latency; compares every completed transfer
  logic [7:0]  lfsr = 8'h5A;
  int          wait_cnt = 0;
  logic        pend = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_wd = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      rsp_valid = 1'b0; rsp_err = 1'b0; pend = 1'b0;
    end else begin
      if (pend) begin
        chk(req_o && addr_o == p_addr && we_o == p_we, "R11 request held", addr_o, p_addr);
        if (p_we) chk(wdata_o == p_wd, "R11 wdata held", wdata_o, p_wd);
      end
      rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0; pend = 1'b0;
      if (req_o) begin
        if (wait_cnt > 0) begin
          wait_cnt--;
          pend = 1'b1; p_addr = addr_o; p_we = we_o; p_wd = wdata_o;
        end else begin
          txn_cnt++;
          if (e_addr.size() == 0) chk(1'b0, "R3 R4 R6 unexpected access", addr_o, 0);
          else begin
            logic [31:0] ea, ed; logic ew;
            ea = e_addr.pop_front(); ew = e_we.pop_front(); ed = e_data.pop_front();
            chk(addr_o == ea && we_o == ew, "R3 R4 R6 access order", {addr_o[30:0], we_o}, {ea[30:0], ew});
            if (ew) chk(wdata_o == ed, "R5 write value", wdata_o, ed);
          end
          if (err_en && !we_o && addr_o == err_addr) rsp_err = 1'b1;
          else if (we_o) mem[addr_o] = wdata_o;
          else rsp_rdata = mrd(addr_o);
          rsp_valid = 1'b1;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          wait_cnt = int'(lfsr % 3);
        end
      end
    end
  end

  task automatic run_walk(input logic [31:0] base, input bit poke);
    int n;
    build(base);
    txn_cnt = 0;
    @(negedge clk); start = 1'b1; base_addr = base;
    @(negedge clk); start = 1'b0; base_addr = 32'hDEAD_0000;
    chk(busy_o && req_o && !we_o && addr_o == base, "R2 first fetch", addr_o, base);
    chk(!err_o, "R9 err cleared by start", err_o, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; base_addr = 32'h0000_0800;
      @(negedge clk); start = 1'b0;
      chk(busy_o, "R10 walk continues", busy_o, 1);
    end
    n = 0;
    while (!done_o && n < 2000) begin @(negedge clk); n++; end
    chk(done_o, "R7 done pulse seen", done_o, 1);
    chk(!busy_o && !req_o, "R7 idle at done", {busy_o, req_o}, 0);
    @(negedge clk);
    chk(!done_o, "R7 done lasts one cycle", done_o, 0);
    chk(e_addr.size() == 0 && txn_cnt == exp_n, "R6 R10 access count", txn_cnt, exp_n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, err_o, req_o, we_o} == 5'b0, "R1 reset outputs", {busy_o, done_o, err_o, req_o, we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, err_o, req_o, we_o} == 5'b0, "R1 after release", {busy_o, done_o, err_o, req_o, we_o}, 0);

    // table A: disjoint masks, overlapping masks, target address zero
    mem[32'h100] = 32'h1000; mem[32'h104] = 32'hF0;        mem[32'h108] = 32'hF;
    mem[32'h10C] = 32'h1004; mem[32'h110] = 32'hFF00_0000; mem[32'h114] = 32'hFF00_0000;
    mem[32'h118] = 32'h0;    mem[32'h11C] = 32'h1;         mem[32'h120] = 32'h0;
    mem[32'h124] = 32'h0;    mem[32'h128] = 32'h0;         mem[32'h12C] = 32'h0;
    mem[32'h1000] = 32'h1234_5678; mem[32'h1004] = 32'hAAAA_AAAA; mem[32'h0] = 32'h10;
    run_walk(32'h100, 1'b1);
    chk(!err_o, "R9 no error on clean walk", err_o, 0);
    chk(mrd(32'h1000) == 32'h1234_56F0, "R5 disjoint masks", mrd(32'h1000), 32'h1234_56F0);
    chk(mrd(32'h1004) == 32'hFFAA_AAAA, "R5 set wins overlap", mrd(32'h1004), 32'hFFAA_AAAA);
    chk(mrd(32'h0) == 32'h11, "R8 address zero target", mrd(32'h0), 32'h11);

    // table B: terminator only
    run_walk(32'h200, 1'b0);
    chk(txn_cnt == 3, "R7 terminator only three fetches", txn_cnt, 3);
    chk(!err_o, "R7 no error on empty table", err_o, 0);

    // table C: bus error on target read
    mem[32'h300] = 32'h2000; mem[32'h304] = 32'h100; mem[32'h308] = 32'h0;
    mem[32'h30C] = 32'h0;    mem[32'h310] = 32'h0;   mem[32'h314] = 32'h0;
    mem[32'h2000] = 32'h55;
    err_en = 1'b1; err_addr = 32'h2000;
    run_walk(32'h300, 1'b0);
    chk(err_o, "R9 error flag set", err_o, 1);
    chk(txn_cnt == 4, "R9 walk aborted", txn_cnt, 4);
    chk(mrd(32'h2000) == 32'h55, "R9 target untouched", mrd(32'h2000), 32'h55);
    repeat (4) @(negedge clk);
    chk(err_o && !busy_o, "R9 error sticky while idle", err_o, 1);

    // table C again without error
    err_en = 1'b0;
    run_walk(32'h300, 1'b0);
    chk(!err_o, "R9 error cleared after clean walk", err_o, 0);
    chk(mrd(32'h2000) == 32'h155, "R5 applied after rerun", mrd(32'h2000), 32'h155);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule